// File: doc/BRIEF.md
# Posted-Write Bridge for Slow-Clock Timekeeping Registers

This block sits between a fast bus clock and a slow timekeeping clock that runs from a crystal. Software writes a small bank of timekeeping registers over the bus, and each write is accepted in one bus cycle. The block holds the value, carries the request into the slow domain and commits it on a later slow-clock tick. The committed value then appears on a wide output that the counters and alarms downstream consume. Each register keeps its own in-flight state. An interrupt status word gathers an aggregate pending bit, a write-complete event and a seconds event. An interrupt output is raised on write completion when the enable bit is set.

Reads return a bus-domain shadow copy of each register and never wait. The shadow takes the new value at the moment the slow domain acknowledges the commit. A single input selects how the slow domain ticks. With the divider on, one tick comes every `DIV` crystal cycles (a 1 Hz rate at the default). With the divider off, every crystal cycle is a tick.

Top module: `rtc_post_sync`

## Requirements
- R1: While reset is asserted, every shadow register and every word of `rtc_q` is zero, the status word reads zero and `irq` is low.
- R2: A write to register index i (address below `NREG`) with no write already in flight for i is accepted in one bus cycle. From the next cycle on, status bit 2 (pending) reads 1.
- R3: Crossing takes two slow-clock edges. The edge after that recognises the request. The value is then committed to `rtc_q` on the second tick that follows. With the divider off, this is the fifth slow-clock edge after acceptance.
- R4: A write to a register whose earlier write is still in flight is ignored. The earlier value is the one that commits and that the shadow shows.
- R5: Writes to different registers may be in flight together. Status bit 2 stays 1 until every one of them has been acknowledged.
- R6: Status bit 1 (write complete) is set one bus cycle after status bit 2 falls. It holds until a status write with bit 1 set clears it.
- R7: Status bit 0 (seconds event) is set after every slow-domain tick. A status write with bit 0 set clears it.
- R8: `irq` is high exactly when status bit 1 is set and bit 0 of the committed value of register 0 (the write-complete enable) is 1.
- R9: A read of address i below `NREG` returns the shadow of register i with no wait. A read of address `NREG` returns the status word, and any other address reads zero. Writing status bit 2 has no effect, and writes to addresses above `NREG` change nothing.
- R10: With `tick_div_en` high, ticks come every `DIV` slow-clock cycles, so a commit lands between the eighth and eleventh edge after acceptance when `DIV` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rtc_clk | input | 1 | Slow crystal clock |
| tick_div_en | input | 1 | 1: tick every DIV crystal cycles; 0: tick every crystal cycle |
| wr_en | input | 1 | Bus write strobe |
| addr | input | AW | Register address; NREG selects the status word |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational from addr |
| irq | output | 1 | Write-complete interrupt |
| rtc_q | output | NREG*DW | Committed register values, slow domain, register i at bits i*DW |

## Verification
A lost or doubled request toggle in either direction leaves a register stuck pending. Status bit 2 then never falls, status bit 1 never sets and `irq` stays low. This shows within a few slow-clock periods of the write. A wrong tick count or a wrong stage count moves the commit edge on `rtc_q`, which is visible at an exact slow-clock edge. A drop rule that is too weak or too strong puts the second value, or no value, into both the shadow and `rtc_q`. The random rounds compare both of these against a model that keeps the first write per register.

// File: rtl/rtc_post_sync.sv
module rtc_post_sync #(
  parameter int NREG = 4,
  parameter int DW   = 32,
  parameter int DIV  = 32768,
  parameter int AW   = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_clk,
  input  logic              tick_div_en,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq,
  output logic [NREG*DW-1:0] rtc_q
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [AW-1:0] ST = AW'(NREG);

  // bus domain
  logic [NREG-1:0][DW-1:0] hold, shadow;
  logic [NREG-1:0] pend, req_t, ack_s1, ack_s2, ack_seen;
  logic [NREG-1:0] ack_t;
  logic pend_q, wc_flag, sec_flag;
  logic sec_t, sec_s1, sec_s2, sec_s3;

  wire [NREG-1:0] ack_evt = ack_s2 ^ ack_seen;
  wire pend_any = |pend;
  wire st_wr    = wr_en && (addr == ST);
  wire sec_evt  = sec_s2 ^ sec_s3;
  logic [NREG-1:0] wr_ok, wr_drop;

  always_comb
    for (int i = 0; i < NREG; i++) begin
      wr_ok[i]   = wr_en && (addr == AW'(i)) && !pend[i];
      wr_drop[i] = wr_en && (addr == AW'(i)) && pend[i];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold <= '0; shadow <= '0; pend <= '0; req_t <= '0;
      ack_s1 <= '0; ack_s2 <= '0; ack_seen <= '0;
    end else begin
      ack_s1 <= ack_t;
      ack_s2 <= ack_s1;
      ack_seen <= ack_s2;
      for (int i = 0; i < NREG; i++)
        if (wr_ok[i]) begin
          hold[i]  <= wdata;
          pend[i]  <= 1'b1;
          req_t[i] <= ~req_t[i];
        end else if (ack_evt[i]) begin
          pend[i]   <= 1'b0;
          shadow[i] <= hold[i];
        end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= 1'b0; wc_flag <= 1'b0; sec_flag <= 1'b0;
      sec_s1 <= 1'b0; sec_s2 <= 1'b0; sec_s3 <= 1'b0;
    end else begin
      pend_q <= pend_any;
      sec_s1 <= sec_t; sec_s2 <= sec_s1; sec_s3 <= sec_s2;
      if (pend_q && !pend_any) wc_flag <= 1'b1;
      else if (st_wr && wdata[1]) wc_flag <= 1'b0;
      if (sec_evt) sec_flag <= 1'b1;
      else if (st_wr && wdata[0]) sec_flag <= 1'b0;
    end

  assign irq = wc_flag & shadow[0][0];

  always_comb begin
    rdata = '0;
    if (addr == ST) rdata[2:0] = {pend_any, wc_flag, sec_flag};
    else
      for (int i = 0; i < NREG; i++)
        if (addr == AW'(i)) rdata = shadow[i];
  end

  // slow domain
  logic pre_s1, pre_s2;
  logic [CW-1:0] cnt;
  logic [NREG-1:0] req_s1, req_s2, req_seen;
  logic [NREG-1:0][1:0] stage;
  logic [NREG-1:0][DW-1:0] rtc_reg;

  wire tick = !pre_s2 || (cnt == CW'(DIV - 1));

  always_ff @(posedge rtc_clk or negedge rst_n)
    if (!rst_n) begin
      pre_s1 <= 1'b0; pre_s2 <= 1'b0; cnt <= '0; sec_t <= 1'b0;
    end else begin
      pre_s1 <= tick_div_en;
      pre_s2 <= pre_s1;
      cnt    <= (!pre_s2 || tick) ? '0 : cnt + 1'b1;
      if (tick) sec_t <= ~sec_t;
    end

  always_ff @(posedge rtc_clk or negedge rst_n)
    if (!rst_n) begin
      req_s1 <= '0; req_s2 <= '0; req_seen <= '0;
      stage <= '0; rtc_reg <= '0; ack_t <= '0;
    end else begin
      req_s1 <= req_t;
      req_s2 <= req_s1;
      for (int i = 0; i < NREG; i++)
        if (req_s2[i] != req_seen[i]) begin
          req_seen[i] <= req_s2[i];
          stage[i]    <= 2'd1;
        end else if (tick && stage[i] == 2'd1) begin
          stage[i] <= 2'd2;
        end else if (tick && stage[i] == 2'd2) begin
          stage[i]   <= 2'd0;
          rtc_reg[i] <= hold[i];
          ack_t[i]   <= ~ack_t[i];
        end
    end

  assign rtc_q = rtc_reg;

  p_post_sets_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    |wr_ok |=> pend_any);
  p_drop_keeps_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    |wr_drop |=> $stable(hold));
  p_wc_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wc_flag) |-> !$past(pend_any) && $past(pend_any, 2));
  p_shadow_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ack_evt) |=> $stable(shadow));
  p_commit_on_tick_r3: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    !tick |=> $stable(rtc_reg));
endmodule

// File: tb/rtc_post_sync_test.sv
module rtc_post_sync_test;
  localparam int NREG = 4, DW = 32, DIV = 4, AW = 3;
  logic clk = 0, rtc_clk = 0, rst_n = 0, tick_div_en = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic irq;
  logic [NREG*DW-1:0] rtc_q;
  int vectors = 0, errors = 0;
  logic [DW-1:0] model [NREG];

  rtc_post_sync #(.NREG(NREG), .DW(DW), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .rtc_clk(rtc_clk), .tick_div_en(tick_div_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rtc_q(rtc_q));

  always #4 clk = ~clk;
  initial begin #3; forever #28 rtc_clk = ~rtc_clk; end

  function automatic logic exp_irq(logic [DW-1:0] ctl, logic wc);
    return ctl[0] & wc;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bread(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [DW-1:0] s;
    for (int k = 0; k < 800; k++) begin
      bread(AW'(NREG), s);
      if (!s[2]) break;
    end
    @(negedge clk); @(negedge clk);
  endtask

  function automatic logic [DW-1:0] slot(int i);
    return rtc_q[i*DW +: DW];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d, s;
    int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < NREG; i++) begin
      bread(AW'(i), d); check("R1 shadow", d, '0);
      check("R1 rtc_q", slot(i), '0);
    end
    bread(AW'(NREG), d); check("R1 status", d, '0);
    check("R1 irq", {31'b0, irq}, '0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2, R3 exact commit edge with divider off
    @(posedge rtc_clk);
    bwrite(AW'(1), 32'hA5A5_0001);
    bread(AW'(NREG), d); check("R2 pending", {31'b0, d[2]}, 32'd1);
    repeat (4) @(posedge rtc_clk);
    #1 check("R3 not yet at edge 4", slot(1), '0);
    @(posedge rtc_clk); #1 check("R3 commit at edge 5", slot(1), 32'hA5A5_0001);
    wait_idle();
    bread(AW'(1), d); check("R9 shadow read", d, 32'hA5A5_0001);
    bread(AW'(NREG), d); check("R6 wc set", {31'b0, d[1]}, 32'd1);
    check("R8 irq off when enable clear", {31'b0, irq}, {31'b0, exp_irq('0, 1'b1)});
    bwrite(AW'(NREG), 32'h2);
    bread(AW'(NREG), d); check("R6 wc cleared", {31'b0, d[1]}, '0);

    // R4 drop of repeat write
    bwrite(AW'(2), 32'h1111_2222);
    bwrite(AW'(2), 32'h3333_4444);
    wait_idle();
    bread(AW'(2), d); check("R4 shadow keeps first", d, 32'h1111_2222);
    check("R4 rtc_q keeps first", slot(2), 32'h1111_2222);

    // R5 overlapping writes
    bwrite(AW'(NREG), 32'h2);
    @(posedge rtc_clk);
    bwrite(AW'(1), 32'hBEEF_0001);
    repeat (3) @(posedge rtc_clk);
    bwrite(AW'(2), 32'hBEEF_0002);
    @(posedge rtc_clk); @(posedge rtc_clk);
    repeat (6) @(negedge clk);
    bread(AW'(1), d); check("R5 first shadow updated", d, 32'hBEEF_0001);
    bread(AW'(2), d); check("R5 second shadow old", d, 32'h1111_2222);
    bread(AW'(NREG), d); check("R5 pending held", {30'b0, d[2:1]}, 32'd2);
    wait_idle();
    bread(AW'(NREG), d); check("R5 all done", {30'b0, d[2:1]}, 32'd1);

    // R9 status pending bit read-only, out-of-range addresses
    bwrite(AW'(NREG), 32'h4);
    bread(AW'(NREG), d); check("R9 pending read-only", {31'b0, d[2]}, '0);
    bwrite(AW'(7), 32'hFFFF_FFFF);
    bread(AW'(7), d); check("R9 unmapped reads zero", d, '0);
    bread(AW'(NREG), d); check("R9 unmapped write no pend", {31'b0, d[2]}, '0);

    // R8 interrupt enable via register 0
    bwrite(AW'(NREG), 32'h2);
    bwrite(AW'(0), 32'h1);
    wait_idle();
    check("R8 irq on", {31'b0, irq}, {31'b0, exp_irq(32'h1, 1'b1)});
    bwrite(AW'(NREG), 32'h2);
    check("R8 irq off after clear", {31'b0, irq}, '0);

    // R7 seconds event
    @(posedge rtc_clk); repeat (4) @(negedge clk);
    bwrite(AW'(NREG), 32'h1);
    bread(AW'(NREG), d); check("R7 sec cleared", {31'b0, d[0]}, '0);
    @(posedge rtc_clk); repeat (4) @(negedge clk);
    bread(AW'(NREG), d); check("R7 sec set after tick", {31'b0, d[0]}, 32'd1);

    // R10 divider on
    tick_div_en = 1;
    repeat (10) @(posedge rtc_clk);
    @(posedge rtc_clk);
    bwrite(AW'(3), 32'h0D1F_0003);
    n = 0;
    repeat (5) begin @(posedge rtc_clk); n++; end
    #1 check("R10 not at edge 5", slot(3), '0);
    while (slot(3) != 32'h0D1F_0003 && n < 20) begin @(posedge rtc_clk); n++; #1; end
    check("R10 commit edge in 8..11", {31'b0, (n >= 8 && n <= 11)}, 32'd1);
    wait_idle();
    tick_div_en = 0;
    repeat (4) @(posedge rtc_clk);

    // random rounds
    model[0] = 32'h1; model[1] = 32'hBEEF_0001; model[2] = 32'hBEEF_0002; model[3] = 32'h0D1F_0003;
    for (int r = 0; r < 25; r++) begin
      logic [NREG-1:0] hit;
      hit = '0;
      bwrite(AW'(NREG), 32'h3);
      for (int k = 0; k < 6; k++) begin
        int i;
        i = int'($urandom_range(NREG - 1));
        d = $urandom;
        bwrite(AW'(i), d);
        if (!hit[i]) begin model[i] = d; hit[i] = 1'b1; end
      end
      wait_idle();
      for (int i = 0; i < NREG; i++) begin
        bread(AW'(i), s); check("R4 random shadow", s, model[i]);
        check("R3 random rtc_q", slot(i), model[i]);
      end
      bread(AW'(NREG), s); check("R6 random wc", {30'b0, s[2:1]}, 32'd1);
      check("R8 random irq", {31'b0, irq}, {31'b0, exp_irq(model[0], 1'b1)});
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule